// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block sits between a clocked host and an asynchronous static RAM of 262,144 sixteen-bit words. The host issues one word per request over a valid/ready port, with an address, a write flag, a two-bit byte mask and write data. The controller turns each request into the RAM's pin sequence: the active-low chip select, output enable and write enable, and one active-low strobe per byte lane. A read returns its data on a one-cycle response pulse.

Every phase is a whole number of clock cycles. The length of each phase is derived from nanosecond parameters and the clock period. It is the ceiling of the time divided by the period, and never less than one cycle. A write ends when write enable rises. Address, data and lane strobes are held for one further cycle after that edge. A read ends with one cycle in which every strobe is high and nothing is driven. Only after that cycle may a write turn on the controller's own data drivers.

The data bus is modelled as separate in and out buses plus a per-lane drive enable. The pad tri-state buffer is outside this block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, chip select, output enable, write enable and both lane strobes are high. Both drive enables are low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only when no transaction is in progress. After a read is accepted, it stays low for RD_CYC+1 cycles. After a write with a non-zero mask is accepted, it stays low for WR_CYC+1 cycles.
- R3: A read with a non-zero mask holds chip select and output enable low and write enable high, with the address steady. The read data appears on `rsp_rdata` with a single-cycle `rsp_valid` exactly RD_CYC+1 cycles after acceptance.
- R4: Mask bit 0 selects data bits 7:0 through `ram_bs_n[0]`. Mask bit 1 selects bits 15:8 through `ram_bs_n[1]`. A strobe is low exactly when its mask bit is set and the RAM is selected. An unselected lane reads back as zero.
- R5: During a write, chip select and write enable are low, output enable is high, and each selected lane drives its data. Write enable then rises. For one further cycle chip select, address, data, strobes and drive enables are held. An unselected lane is never driven and its RAM byte is unchanged.
- R6: After every read phase there is one cycle in which all strobes are high and no lane is driven.
- R7: No lane drive enable is ever high while output enable is low.
- R8: A request with mask 00 asserts no strobe. A read with mask 00 gets `rsp_valid` with zero data one cycle after acceptance. A write with mask 00 produces no response.
- R9: RD_CYC = ceil(T_RC_NS/CLK_NS). WR_CYC = max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS), ceil(T_WC_NS/CLK_NS)-1). Each value is at least 1. Output enable is low for exactly RD_CYC cycles per read and write enable for exactly WR_CYC cycles per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | 18 | RAM address |
| ram_dq_o | output | 16 | Data toward the RAM |
| ram_dq_oe | output | 2 | Per-lane drive enable for ram_dq_o |
| ram_dq_i | input | 16 | Data from the RAM |
| ram_ce_n | output | 1 | Chip select, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_bs_n | output | 2 | Lane strobes, active low, bit 0 = lower byte |

## Verification
The embedded assertions check pin rules that must hold on every cycle. They check that no lane is driven while output enable is low and that drivers are off on the edge where output enable rises. They check that write enable is low only with chip select low and output enable high, and that address, strobes and select hold on the cycle write enable rises. They also check that the response pulse lasts one cycle and that the controller is ready only while deselected. Exact phase lengths, response latency, lane merging in the RAM, zero-mask behaviour and returned data depend on request history. Only the bench's scenarios can show these, using a pin-level RAM model and a shadow memory.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_HOLD
    } ctl_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } ram_ctl_t;

    function automatic int ceil_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int wr_cycles(input int pwe_ns, input int sd_ns,
                                     input int wc_ns, input int clk_ns);
        int a, b, c, m;
        a = ceil_cycles(pwe_ns, clk_ns);
        b = ceil_cycles(sd_ns, clk_ns);
        c = ceil_cycles(wc_ns, clk_ns) - 1;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return (m < 1) ? 1 : m;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len - CNT_W'(1);
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int LANES  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drive,
    input  logic              capture,
    input  logic              clear,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [LANES-1:0]  dq_oe,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = DATA_W / LANES;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dq_o[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
        assign dq_oe[l] = drive & mask[l];

        always_ff @(posedge clk) begin
            if (rst || clear)
                rdata[l*LANE_W +: LANE_W] <= '0;
            else if (capture)
                rdata[l*LANE_W +: LANE_W] <= mask[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 10,
    parameter int T_PWE_NS = 8,
    parameter int T_SD_NS  = 6,
    parameter int T_WC_NS  = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic [DATA_W/8-1:0] req_mask,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_dq_o,
    output logic [DATA_W/8-1:0] ram_dq_oe,
    input  logic [DATA_W-1:0]   ram_dq_i,
    output logic                ram_ce_n,
    output logic                ram_oe_n,
    output logic                ram_we_n,
    output logic [DATA_W/8-1:0] ram_bs_n
);
    localparam int LANES  = DATA_W / 8;
    localparam int RD_CYC = ceil_cycles(T_RC_NS, CLK_NS);
    localparam int WR_CYC = wr_cycles(T_PWE_NS, T_SD_NS, T_WC_NS, CLK_NS);
    localparam int MAX_C  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C + 1);

    ctl_state_e         state;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [LANES-1:0]   mask_q;
    logic               accept, zero_req, phase_done;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_len;
    logic               selected;
    ram_ctl_t           ctl;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid & req_ready;
    assign zero_req  = (req_mask == '0);

    assign tmr_load = accept & ~zero_req;
    assign tmr_len  = req_write ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);

    sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .done (phase_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    mask_q  <= req_mask;
                    if (!zero_req)
                        state <= req_write ? ST_WRITE : ST_READ;
                end
                ST_READ:  if (phase_done) state <= ST_TURN;
                ST_TURN:  state <= ST_IDLE;
                ST_WRITE: if (phase_done) state <= ST_HOLD;
                ST_HOLD:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_valid <= 1'b0;
        else
            rsp_valid <= ((state == ST_READ) && phase_done) ||
                         (accept && zero_req && !req_write);
    end

    assign selected = (state == ST_READ) || (state == ST_WRITE) || (state == ST_HOLD);

    always_comb begin
        ctl.ce_n = ~selected;
        ctl.oe_n = (state != ST_READ);
        ctl.we_n = (state != ST_WRITE);
    end

    assign ram_ce_n = ctl.ce_n;
    assign ram_oe_n = ctl.oe_n;
    assign ram_we_n = ctl.we_n;
    assign ram_bs_n = selected ? ~mask_q : '1;
    assign ram_addr = addr_q;

    sram_lane_io #(.LANES(LANES), .DATA_W(DATA_W)) u_io (
        .clk     (clk),
        .rst     (rst),
        .drive   ((state == ST_WRITE) || (state == ST_HOLD)),
        .capture ((state == ST_READ) && phase_done),
        .clear   (accept && zero_req && !req_write),
        .mask    (mask_q),
        .wdata   (wdata_q),
        .dq_i    (ram_dq_i),
        .dq_o    (ram_dq_o),
        .dq_oe   (ram_dq_oe),
        .rdata   (rsp_rdata)
    );

    // R7
    no_drive_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_dq_oe != '0) |-> ram_oe_n);

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_oe_n) |-> (ram_dq_oe == '0) && (ram_bs_n == '1));

    // R5
    we_context_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !ram_ce_n && ram_oe_n);

    // R5
    write_end_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> !ram_ce_n && $stable(ram_addr) && $stable(ram_bs_n) && $stable(ram_dq_o));

    // R3
    rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ram_ce_n && ram_we_n && ram_oe_n);
endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    localparam int EXP_RD = 3;  // ceil(25/10)
    localparam int EXP_WR = 2;  // max(ceil(18/10), ceil(6/10), ceil(30/10)-1)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready, rsp_valid;
    logic [17:0] req_addr = '0, ram_addr;
    logic [1:0]  req_mask = '0, ram_dq_oe, ram_bs_n;
    logic [15:0] req_wdata = '0, rsp_rdata, ram_dq_o, ram_dq_i;
    logic        ram_ce_n, ram_oe_n, ram_we_n;

    always #5 clk = ~clk;

    sram_lane_ctrl #(.T_RC_NS(25), .T_PWE_NS(18), .T_WC_NS(30)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_mask(req_mask),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
        .ram_dq_i(ram_dq_i), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ram_bs_n(ram_bs_n));

    int compared = 0, mismatched = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // pin-level RAM model and host-side shadow
    logic [15:0] pin_mem [int];
    logic [15:0] shadow [int];

    function automatic logic [15:0] rd_pin(input int a);
        return pin_mem.exists(a) ? pin_mem[a] : 16'h0;
    endfunction
    function automatic logic [15:0] rd_sh(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0;
    endfunction
    function automatic logic [15:0] lanes(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    logic [1:0]  dev_drv;
    logic [15:0] cur_word;
    always @(*) begin
        for (int l = 0; l < 2; l++)
            dev_drv[l] = !ram_ce_n && !ram_oe_n && ram_we_n && !ram_bs_n[l];
        cur_word = rd_pin(int'(ram_addr));
        ram_dq_i = {dev_drv[1] ? cur_word[15:8] : 8'h5A, dev_drv[0] ? cur_word[7:0] : 8'hC3};
    end

    logic [1:0]  prev_act = '0;
    logic [17:0] prev_addr = '0;
    logic [15:0] prev_dq = '0;
    int          exp_cyc [$];
    logic [15:0] exp_dat [$];
    int          busy_until = 0, we_len = 0, rd_len = 0;
    bit          zero_pending = 0;
    logic [1:0]  cur_mask = '0;
    logic [17:0] cur_addr = '0;
    logic [15:0] cur_data = '0;

    always @(negedge clk) begin
        if (!rst) begin
            logic [1:0] act;
            logic [15:0] w;
            cyc++;
            // RAM model: commit lane when its write window closes
            for (int l = 0; l < 2; l++) begin
                act[l] = !ram_ce_n && !ram_we_n && !ram_bs_n[l];
                if (prev_act[l] && !act[l]) begin
                    w = rd_pin(int'(prev_addr));
                    w[l*8 +: 8] = prev_dq[l*8 +: 8];
                    pin_mem[int'(prev_addr)] = w;
                end
            end
            if (act != 2'b00) begin
                prev_addr = ram_addr;
                prev_dq   = ram_dq_o;
            end
            prev_act = act;

            // R7 bus contention
            chk((ram_dq_oe & dev_drv) == 2'b00, "R7 contention", 32'(ram_dq_oe), 32'(0));

            // R3 response timing and data
            if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                chk(rsp_valid == 1'b1, "R3 rsp_valid", 32'(rsp_valid), 32'(1));
                chk(rsp_rdata == exp_dat[0], "R3 R4 rsp_rdata", 32'(rsp_rdata), 32'(exp_dat[0]));
                void'(exp_cyc.pop_front());
                void'(exp_dat.pop_front());
            end else begin
                chk(rsp_valid == 1'b0, "R3 spurious rsp_valid", 32'(rsp_valid), 32'(0));
            end

            // R2 ready only when idle
            chk(req_ready == (cyc > busy_until), "R2 req_ready", 32'(req_ready), 32'(cyc > busy_until));

            // R5 / R9 write phase
            if (!ram_we_n) begin
                we_len++;
                chk(!ram_ce_n && ram_oe_n && ram_bs_n == ~cur_mask && ram_dq_oe == cur_mask
                    && ram_addr == cur_addr && (ram_dq_o & lanes(cur_mask)) == (cur_data & lanes(cur_mask)),
                    "R5 write pins", {14'd0, ram_addr}, {14'd0, cur_addr});
            end else if (we_len != 0) begin
                chk(we_len == EXP_WR, "R9 write length", 32'(we_len), 32'(EXP_WR));
                chk(!ram_ce_n && ram_bs_n == ~cur_mask && ram_dq_oe == cur_mask && ram_addr == cur_addr
                    && (ram_dq_o & lanes(cur_mask)) == (cur_data & lanes(cur_mask)),
                    "R5 hold cycle", {28'd0, ram_bs_n, ram_dq_oe}, {28'd0, ~cur_mask, cur_mask});
                we_len = 0;
            end

            // R3 / R4 / R6 / R9 read phase
            if (!ram_oe_n) begin
                rd_len++;
                chk(ram_we_n && !ram_ce_n && ram_bs_n == ~cur_mask && ram_addr == cur_addr,
                    "R4 read strobes", {30'd0, ram_bs_n}, {30'd0, ~cur_mask});
            end else if (rd_len != 0) begin
                chk(rd_len == EXP_RD, "R9 read length", 32'(rd_len), 32'(EXP_RD));
                chk(ram_ce_n && ram_bs_n == 2'b11 && ram_dq_oe == 2'b00, "R6 turnaround",
                    {29'd0, ram_ce_n, ram_dq_oe}, {29'd0, 1'b1, 2'b00});
                rd_len = 0;
            end

            // R8 zero mask: nothing strobed
            if (zero_pending) begin
                chk(ram_ce_n && ram_we_n && ram_oe_n && ram_bs_n == 2'b11, "R8 no strobe",
                    {30'd0, ram_bs_n}, {30'd0, 2'b11});
                zero_pending = 0;
            end

            // acceptance bookkeeping
            if (req_valid && req_ready) begin
                cur_mask = req_mask;
                cur_addr = req_addr;
                cur_data = req_wdata;
                if (req_mask == 2'b00) begin
                    zero_pending = 1;
                    busy_until = cyc;
                    if (!req_write) begin
                        exp_cyc.push_back(cyc + 1);
                        exp_dat.push_back(16'h0);
                    end
                end else if (req_write) begin
                    busy_until = cyc + EXP_WR + 1;
                    shadow[int'(req_addr)] = (rd_sh(int'(req_addr)) & ~lanes(req_mask))
                                           | (req_wdata & lanes(req_mask));
                end else begin
                    busy_until = cyc + EXP_RD + 1;
                    exp_cyc.push_back(cyc + EXP_RD + 1);
                    exp_dat.push_back(rd_sh(int'(req_addr)) & lanes(req_mask));
                end
            end
        end
    end

    task automatic do_req(input bit wr, input logic [17:0] a, input logic [1:0] m, input logic [15:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired (R2 hang) actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state while reset held
        chk(ram_ce_n && ram_oe_n && ram_we_n && ram_bs_n == 2'b11 && ram_dq_oe == 2'b00
            && req_ready && !rsp_valid, "R1 reset pins",
            {26'd0, ram_ce_n, ram_oe_n, ram_we_n, ram_bs_n, req_ready}, {26'd0, 6'b111111});
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(ram_ce_n && ram_dq_oe == 2'b00 && req_ready && !rsp_valid, "R1 after reset",
            {29'd0, ram_ce_n, ram_dq_oe}, {29'd0, 3'b100});

        // full-word write/read, read straight after write (R3, R5)
        do_req(1, 18'h00123, 2'b11, 16'hBEEF);
        do_req(0, 18'h00123, 2'b11, 16'h0);
        // lower-lane write, merged readback (R4, R5)
        do_req(1, 18'h00123, 2'b01, 16'h1234);
        do_req(0, 18'h00123, 2'b11, 16'h0);
        // upper-lane write then lane-masked reads (R4)
        do_req(1, 18'h00123, 2'b10, 16'hA5FF);
        do_req(0, 18'h00123, 2'b10, 16'h0);
        do_req(0, 18'h00123, 2'b01, 16'h0);
        // zero-mask write must not change memory, zero-mask read (R8)
        do_req(1, 18'h00123, 2'b00, 16'hFFFF);
        do_req(0, 18'h00123, 2'b00, 16'h0);
        do_req(0, 18'h00123, 2'b11, 16'h0);
        // address boundaries
        do_req(1, 18'h00000, 2'b11, 16'h0F0F);
        do_req(1, 18'h3FFFF, 2'b11, 16'hF00D);
        do_req(0, 18'h3FFFF, 2'b11, 16'h0);
        do_req(0, 18'h00000, 2'b11, 16'h0);
        // read followed immediately by write (R6 turnaround before drive)
        do_req(0, 18'h3FFFF, 2'b01, 16'h0);
        do_req(1, 18'h3FFFF, 2'b10, 16'h7700);
        do_req(0, 18'h3FFFF, 2'b11, 16'h0);
        // computed pattern sweep
        for (int i = 0; i < 24; i++)
            do_req(1, 18'(i * 4099 + 7), 2'(i % 4), 16'(i * 40503 + 17));
        for (int i = 0; i < 24; i++)
            do_req(0, 18'(i * 4099 + 7), 2'((i + 1) % 4), 16'h0);

        repeat (10) @(negedge clk);
        chk(exp_cyc.size() == 0, "R3 responses outstanding", 32'(exp_cyc.size()), 32'(0));
        // R5 pin-level RAM contents match the host shadow
        foreach (shadow[k])
            chk(rd_pin(k) == shadow[k], "R5 RAM contents", 32'(rd_pin(k)), 32'(shadow[k]));
        summary();
    end
endmodule